// File: doc/BRIEF.md
# Strobe-Interlocked Bus Slave Responder

This block is the target side of an asynchronous, strobe-handshaked parallel bus, rebuilt as synchronous logic. The bus control lines are first passed through two-flop synchronizers. When the address strobe goes low, the block captures the address, the modifier code and the width line. It then decides whether the cycle falls inside its window, defined by a base and a mask. A cycle that hits the window waits for a data strobe. If the modifier or the width is not supported, the cycle ends with a bus-error. Otherwise the block completes the transfer against a small internal word store and signals acknowledge.

The outputs are pull-low enables for open-drain lines: one for acknowledge, one for bus-error, and one enable per byte lane of the data bus. The response is always interlocked with the master's strobes. Read data is placed on the bus before acknowledge is given and is held until the strobes return high. The data lanes are then freed, and acknowledge is released one clock later. While the address strobe stays low, further strobe cycles reuse the captured address. This lets a read followed by a write act as an indivisible read-modify-write.

Top module: `bus_slave_resp`

## Requirements
- R1: A cycle is selected only when (address & MASK) equals (BASE & MASK) at the fall of the address strobe. For a cycle outside this window, acknowledge, bus-error and every data lane enable stay deasserted for the whole cycle.
- R2: Acknowledge and bus-error are never asserted while the address strobe alone is low. Each appears only after a data strobe has been seen low.
- R3: A cycle in the window that uses an unsupported modifier (anything other than 0x39 or 0x3D) or a 32-bit width (width line low) is ended with bus-error. No data lane is driven and the store is left unchanged.
- R4: On a read, the data strobe pattern selects the lanes. Strobe 0 alone drives data bits 7:0 (lane enable 2'b01). Strobe 1 alone drives bits 15:8 (2'b10). Both strobes drive the full word (2'b11). The lanes are enabled before acknowledge is asserted.
- R5: On a read, the data output and the lane enables remain unchanged for as long as acknowledge is asserted and the strobes stay low.
- R6: When the data strobes return high, the lane enables drop first. Acknowledge (or bus-error) is released at least one clock after the lanes are free.
- R7: A write stores only the byte lanes whose data strobe is low, into the word addressed by address bits [IDX_W:1]. The other byte of that word keeps its value. The write is committed in the same clock in which acknowledge is asserted.
- R8: While the address strobe stays low, a second data strobe cycle uses the address captured at the fall of the address strobe. Changes on the address lines are ignored, so a read then write acts as a read-modify-write.
- R9: After reset, all output enables are deasserted and every word of the store reads as zero.
- R10: If the address strobe rises before any data strobe arrives, the block returns to idle without responding, and it accepts the next cycle normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| as_n | input | 1 | Address strobe, active low |
| ds_n | input | 2 | Data strobes, active low; bit 0 selects the low byte lane, bit 1 the high byte lane |
| write_n | input | 1 | Low for write, high for read |
| lword_n | input | 1 | Width line; low requests a 32-bit transfer (not supported) |
| am | input | 6 | Address modifier code |
| addr | input | ADDR_W-1 | Address lines A[ADDR_W-1:1] |
| data_in | input | 16 | Data lines as seen by the slave |
| data_out | output | 16 | Data presented when lanes are enabled |
| data_oe | output | 2 | Per-lane data driver enable (bit 0 = bits 7:0) |
| dtack_oe | output | 1 | Pull the acknowledge line low |
| berr_oe | output | 1 | Pull the bus-error line low |

## Verification
Two things can be decided in the same clock. The capture of the address can coincide with the first sight of the data strobe, and on a write the commit to the store coincides with the assertion of acknowledge. The first case is provoked by dropping the address strobe and a data strobe on the same bench edge, so that both pass through the synchronizers together. It is judged by requiring the correct lanes, the correct data and a lanes-before-acknowledge order. The second case is judged by reading the word back through a normal bus cycle and checking that only the strobed byte changed, including a read-modify-write done while the address lines hold a different address.

// File: rtl/bsr_pkg.sv
package bsr_pkg;

  localparam int LANE_W = 8;
  localparam int LANES  = 2;
  localparam int DATA_W = LANE_W * LANES;

  typedef enum logic [2:0] {
    ST_IDLE,   // waiting for the address strobe
    ST_MISS,   // not ours; wait for the strobe to rise
    ST_ADDR,   // selected, waiting for a data strobe
    ST_DRIVE,  // read data on the lanes, acknowledge next
    ST_RESP,   // response asserted, waiting for strobe release
    ST_REL     // lanes freed, acknowledge being released
  } st_e;

  // Bit mask covering the byte lanes that are strobed.
  function automatic logic [DATA_W-1:0] lane_mask(input logic [LANES-1:0] lanes);
    logic [DATA_W-1:0] m;
    for (int i = 0; i < LANES; i++) m[i*LANE_W +: LANE_W] = {LANE_W{lanes[i]}};
    return m;
  endfunction

  // Replace the strobed lanes of an old word by new data.
  function automatic logic [DATA_W-1:0] merge_lanes(input logic [DATA_W-1:0] old_w,
                                                    input logic [DATA_W-1:0] new_w,
                                                    input logic [LANES-1:0]  lanes);
    logic [DATA_W-1:0] m;
    m = lane_mask(lanes);
    return (old_w & ~m) | (new_w & m);
  endfunction

endpackage

// File: rtl/bsr_sync.sv
module bsr_sync #(
  parameter int W = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  // Resets to all ones: every synchronized line is active low.
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= '1;
    end else begin
      chain[0] <= d;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/bsr_decode.sv
module bsr_decode #(
  parameter int               ADDR_W    = 24,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 'h40_0000,
  parameter logic [ADDR_W-1:0] WIN_MASK  = 'hFF_0000,
  parameter logic [5:0]        AM_CODE_A = 6'h39,
  parameter logic [5:0]        AM_CODE_B = 6'h3D
) (
  input  logic [ADDR_W-1:1] addr_in,
  input  logic [5:0]        am_in,
  input  logic              lword_n_in,
  output logic              hit,
  output logic              legal
);
  localparam logic [ADDR_W-1:1] MASK_HI = WIN_MASK[ADDR_W-1:1];
  localparam logic [ADDR_W-1:1] BASE_HI = BASE_ADDR[ADDR_W-1:1] & MASK_HI;

  logic am_ok;

  assign hit   = (addr_in & MASK_HI) == BASE_HI;
  assign am_ok = (am_in == AM_CODE_A) || (am_in == AM_CODE_B);
  // 32-bit requests are not supported by this 16-bit slave.
  assign legal = am_ok && lword_n_in;
endmodule

// File: rtl/bsr_store.sv
module bsr_store
  import bsr_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  idx,
  input  logic              wr_en,
  input  logic [LANES-1:0]  wr_lanes,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[idx] <= merge_lanes(mem[idx], wr_data, wr_lanes);
    end
  end

  assign rd_data = mem[idx];
endmodule

// File: rtl/bus_slave_resp.sv
module bus_slave_resp
  import bsr_pkg::*;
#(
  parameter int               ADDR_W    = 24,
  parameter int               DEPTH     = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 'h40_0000,
  parameter logic [ADDR_W-1:0] WIN_MASK  = 'hFF_0000,
  parameter logic [5:0]        AM_CODE_A = 6'h39,
  parameter logic [5:0]        AM_CODE_B = 6'h3D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              as_n,
  input  logic [1:0]        ds_n,
  input  logic              write_n,
  input  logic              lword_n,
  input  logic [5:0]        am,
  input  logic [ADDR_W-1:1] addr,
  input  logic [15:0]       data_in,
  output logic [15:0]       data_out,
  output logic [1:0]        data_oe,
  output logic              dtack_oe,
  output logic              berr_oe
);
  localparam int IDX_W  = $clog2(DEPTH);
  localparam int SYNC_W = 1 + LANES + 1;

  // ---------------- synchronized control lines ----------------
  logic [SYNC_W-1:0] sync_q;
  logic              as_act;
  logic [LANES-1:0]  ds_act;
  logic              ds_any;
  logic              is_write;

  bsr_sync #(.W(SYNC_W), .STAGES(2)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({as_n, ds_n, write_n}),
    .q    (sync_q)
  );

  assign as_act   = ~sync_q[SYNC_W-1];
  assign ds_act   = ~sync_q[LANES:1];
  assign ds_any   = |ds_act;
  assign is_write = ~sync_q[0];

  // ---------------- address decode ----------------
  logic dec_hit, dec_legal;

  bsr_decode #(
    .ADDR_W   (ADDR_W),
    .BASE_ADDR(BASE_ADDR),
    .WIN_MASK (WIN_MASK),
    .AM_CODE_A(AM_CODE_A),
    .AM_CODE_B(AM_CODE_B)
  ) u_dec (
    .addr_in   (addr),
    .am_in     (am),
    .lword_n_in(lword_n),
    .hit       (dec_hit),
    .legal     (dec_legal)
  );

  // ---------------- state ----------------
  st_e               st;
  logic [ADDR_W-1:1] lat_addr;
  logic              lat_ok;
  logic [DATA_W-1:0] data_q;
  logic [LANES-1:0]  oe_q;
  logic              dtack_q, berr_q;
  logic [DATA_W-1:0] store_rd;

  // Named internal events.
  logic as_capture;    // address strobe seen in idle
  logic ds_start;      // first data strobe sample of a selected cycle
  logic err_set;       // bus-error decision
  logic wr_commit;     // store write, same clock as acknowledge
  logic rd_load;       // read data loaded onto lanes
  logic lanes_free;    // strobes released, lanes dropped
  logic resp_release;  // acknowledge / bus-error released

  assign as_capture   = (st == ST_IDLE) && as_act;
  assign ds_start     = (st == ST_ADDR) && as_act && ds_any;
  assign err_set      = ds_start && !lat_ok;
  assign wr_commit    = ds_start && lat_ok && is_write;
  assign rd_load      = ds_start && lat_ok && !is_write;
  assign lanes_free   = (st == ST_RESP) && !ds_any;
  assign resp_release = (st == ST_REL);

  bsr_store #(.DEPTH(DEPTH)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .idx     (lat_addr[IDX_W:1]),
    .wr_en   (wr_commit),
    .wr_lanes(ds_act),
    .wr_data (data_in),
    .rd_data (store_rd)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      lat_addr <= '0;
      lat_ok   <= 1'b0;
      data_q   <= '0;
      oe_q     <= '0;
      dtack_q  <= 1'b0;
      berr_q   <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: if (as_capture) begin
          lat_addr <= addr;
          lat_ok   <= dec_legal;
          st       <= dec_hit ? ST_ADDR : ST_MISS;
        end
        ST_MISS: if (!as_act) st <= ST_IDLE;
        ST_ADDR: begin
          if (!as_act) begin
            st <= ST_IDLE;
          end else if (err_set) begin
            berr_q <= 1'b1;
            st     <= ST_RESP;
          end else if (wr_commit) begin
            dtack_q <= 1'b1;
            st      <= ST_RESP;
          end else if (rd_load) begin
            data_q <= store_rd & lane_mask(ds_act);
            oe_q   <= ds_act;
            st     <= ST_DRIVE;
          end
        end
        ST_DRIVE: begin
          dtack_q <= 1'b1;
          st      <= ST_RESP;
        end
        ST_RESP: if (lanes_free) begin
          oe_q <= '0;
          st   <= ST_REL;
        end
        ST_REL: begin
          dtack_q <= 1'b0;
          berr_q  <= 1'b0;
          st      <= as_act ? ST_ADDR : ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign data_out = data_q;
  assign data_oe  = oe_q;
  assign dtack_oe = dtack_q;
  assign berr_oe  = berr_q;

  // ---------------- assertions ----------------
  // R1: a cycle outside the window never produces any drive
  a_r1_miss_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_MISS) |-> (!dtack_oe && !berr_oe && data_oe == '0));

  // R2: a response rises only after a data strobe was sampled low
  a_r2_resp_after_ds: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(dtack_oe) || $rose(berr_oe)) |-> ($past(ds_any) || $past(ds_any, 2)));

  // R2: acknowledge and bus-error are exclusive
  a_r2_single_resp: assert property (@(posedge clk) disable iff (!rst_n)
    !(dtack_oe && berr_oe));

  // R3: bus-error never drives data nor writes the store
  a_r3_err_no_data: assert property (@(posedge clk) disable iff (!rst_n)
    berr_oe |-> (data_oe == '0 && !wr_commit));

  // R4: read lanes are on before acknowledge rises
  a_r4_data_before_ack: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(dtack_oe) && data_oe != '0) |-> ($past(data_oe) != '0));

  // R5: read data held steady while acknowledged
  a_r5_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (dtack_oe && $past(dtack_oe) && data_oe != '0) |-> ($stable(data_out) && $stable(data_oe)));

  // R6: lanes freed at least a clock before acknowledge releases
  a_r6_release_order: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dtack_oe) |-> (data_oe == '0 && $past(data_oe) == '0));

  // R7: store commit coincides with acknowledge rising
  a_r7_commit_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |=> $rose(dtack_oe));

endmodule

// File: tb/bus_slave_resp_test.sv
module bus_slave_resp_test;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        as_n, write_n, lword_n;
  logic [1:0]  ds_n;
  logic [5:0]  am;
  logic [23:1] addr;
  logic [15:0] data_in, data_out;
  logic [1:0]  data_oe;
  logic        dtack_oe, berr_oe;

  int checks = 0;
  int errors = 0;

  always #(CLK_P/2) clk = ~clk;

  bus_slave_resp uut (
    .clk(clk), .rst_n(rst_n), .as_n(as_n), .ds_n(ds_n), .write_n(write_n),
    .lword_n(lword_n), .am(am), .addr(addr), .data_in(data_in),
    .data_out(data_out), .data_oe(data_oe), .dtack_oe(dtack_oe), .berr_oe(berr_oe)
  );

  // resp coding: 0 none, 1 acknowledge, 2 bus-error
  typedef struct packed {
    logic        wr;
    logic [1:0]  lanes;
    logic [23:0] a;
    logic [5:0]  m;
    logic        lw;
    logic [15:0] wd;
    logic [1:0]  resp;
    logic [15:0] rd;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 2'b11, 24'h400002, 6'h39, 1'b1, 16'hA5C3, 2'd1, 16'h0000, 8'd7},
    '{1'b0, 2'b11, 24'h400002, 6'h39, 1'b1, 16'h0000, 2'd1, 16'hA5C3, 8'd4},
    '{1'b1, 2'b01, 24'h400002, 6'h3D, 1'b1, 16'hFF12, 2'd1, 16'h0000, 8'd7},
    '{1'b0, 2'b11, 24'h400002, 6'h39, 1'b1, 16'h0000, 2'd1, 16'hA512, 8'd7},
    '{1'b1, 2'b10, 24'h400004, 6'h3D, 1'b1, 16'h7734, 2'd1, 16'h0000, 8'd7},
    '{1'b0, 2'b10, 24'h400004, 6'h39, 1'b1, 16'h0000, 2'd1, 16'h7700, 8'd4},
    '{1'b0, 2'b01, 24'h400002, 6'h39, 1'b1, 16'h0000, 2'd1, 16'h0012, 8'd4},
    '{1'b0, 2'b11, 24'h500002, 6'h39, 1'b1, 16'h0000, 2'd0, 16'h0000, 8'd1},
    '{1'b1, 2'b11, 24'h400002, 6'h09, 1'b1, 16'hFFFF, 2'd2, 16'h0000, 8'd3},
    '{1'b0, 2'b11, 24'h400002, 6'h39, 1'b0, 16'h0000, 2'd2, 16'h0000, 8'd3},
    '{1'b0, 2'b11, 24'h400002, 6'h39, 1'b1, 16'h0000, 2'd1, 16'hA512, 8'd3},
    '{1'b0, 2'b11, 24'h40001E, 6'h39, 1'b1, 16'h0000, 2'd1, 16'h0000, 8'd9}
  };

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] lmask(input logic [1:0] l);
    return {{8{l[1]}}, {8{l[0]}}};
  endfunction

  // One strobe cycle. as_held: address strobe already low (second cycle of RMW).
  // joint: drop address and data strobes together. hold: clocks to keep strobes low after response.
  task automatic bus_cycle(input logic [23:0] a, input logic [5:0] m, input logic lw,
                           input logic wr, input logic [1:0] ln, input logic [15:0] wd,
                           input logic as_held, input logic keep_as, input logic joint,
                           input int hold, output logic [1:0] resp, output logic [15:0] rd);
    logic [1:0] prev_oe;
    logic [15:0] snap;
    resp = 2'd0; rd = '0;
    @(negedge clk);
    addr = a[23:1]; am = m; lword_n = lw; write_n = ~wr; data_in = wd;
    if (!as_held) begin
      @(negedge clk);
      as_n = 1'b0;
      if (!joint) @(negedge clk);
    end
    ds_n = ~ln;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (dtack_oe) begin
        resp = 2'd1; rd = data_out;
        if (!wr) chk(data_oe == ln, "R4 lanes", data_oe, ln);
        break;
      end
      if (berr_oe) begin
        resp = 2'd2;
        chk(data_oe == 2'b00, "R3 no data on error", data_oe, 0);
        break;
      end
    end
    snap = data_out;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk(dtack_oe && data_oe == ln && data_out == snap, "R5 hold", data_out, snap);
    end
    prev_oe = data_oe;
    ds_n = 2'b11;
    if (resp != 2'd0) begin
      for (int i = 0; i < 30; i++) begin
        @(negedge clk);
        if (!dtack_oe && !berr_oe) begin
          chk(data_oe == 2'b00 && prev_oe == 2'b00, "R6 release order", prev_oe, 0);
          break;
        end
        prev_oe = data_oe;
      end
    end
    if (!keep_as) as_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [1:0] r;
    logic [15:0] d;
    rst_n = 1'b0; as_n = 1'b1; ds_n = 2'b11; write_n = 1'b1; lword_n = 1'b1;
    am = 6'h39; addr = '0; data_in = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9: reset state
    chk(!dtack_oe && !berr_oe && data_oe == 2'b00, "R9 reset outputs",
        {dtack_oe, berr_oe, data_oe}, 0);

    // Vector walk
    for (int v = 0; v < NV; v++) begin
      bus_cycle(VEC[v].a, VEC[v].m, VEC[v].lw, VEC[v].wr, VEC[v].lanes, VEC[v].wd,
                1'b0, 1'b0, 1'b0, 0, r, d);
      chk(r == VEC[v].resp, $sformatf("R%0d resp vec%0d", VEC[v].req, v), r, VEC[v].resp);
      if (VEC[v].resp == 2'd1 && !VEC[v].wr)
        chk((d & lmask(VEC[v].lanes)) == VEC[v].rd,
            $sformatf("R%0d data vec%0d", VEC[v].req, v), d, VEC[v].rd);
    end

    // R2 / R10: address strobe alone, then released without a data strobe
    @(negedge clk);
    addr = 23'h200001; am = 6'h39; lword_n = 1'b1; write_n = 1'b1;
    @(negedge clk);
    as_n = 1'b0;
    begin
      logic seen;
      seen = 1'b0;
      for (int i = 0; i < 12; i++) begin
        @(negedge clk);
        if (dtack_oe || berr_oe) seen = 1'b1;
      end
      chk(!seen, "R2 no response without data strobe", seen, 0);
    end
    as_n = 1'b1;
    repeat (6) @(negedge clk);
    chk(!dtack_oe && !berr_oe, "R10 idle after abandoned cycle", {dtack_oe, berr_oe}, 0);
    bus_cycle(24'h400004, 6'h39, 1'b1, 1'b0, 2'b11, 16'h0, 1'b0, 1'b0, 1'b0, 0, r, d);
    chk(r == 2'd1 && d == 16'h7700, "R10 next cycle served", d, 16'h7700);

    // R8: read-modify-write with address lines changed before the write
    bus_cycle(24'h400004, 6'h39, 1'b1, 1'b0, 2'b11, 16'h0, 1'b0, 1'b1, 1'b0, 0, r, d);
    chk(r == 2'd1 && d == 16'h7700, "R8 rmw read", d, 16'h7700);
    bus_cycle(24'h500000, 6'h39, 1'b1, 1'b1, 2'b01, 16'h0057, 1'b1, 1'b0, 1'b0, 0, r, d);
    chk(r == 2'd1, "R8 rmw write ack", r, 1);
    bus_cycle(24'h400004, 6'h39, 1'b1, 1'b0, 2'b11, 16'h0, 1'b0, 1'b0, 1'b0, 0, r, d);
    chk(d == 16'h7757, "R8 rmw used latched address", d, 16'h7757);
    bus_cycle(24'h400000, 6'h39, 1'b1, 1'b0, 2'b11, 16'h0, 1'b0, 1'b0, 1'b0, 0, r, d);
    chk(d == 16'h0000, "R8 other word untouched", d, 0);

    // R5: long hold after acknowledge; R4 with joint strobes
    bus_cycle(24'h400002, 6'h39, 1'b1, 1'b0, 2'b11, 16'h0, 1'b0, 1'b0, 1'b0, 6, r, d);
    chk(d == 16'hA512, "R5 held read value", d, 16'hA512);
    bus_cycle(24'h400002, 6'h3D, 1'b1, 1'b0, 2'b10, 16'h0, 1'b0, 1'b0, 1'b1, 0, r, d);
    chk(r == 2'd1 && (d & 16'hFF00) == 16'hA500, "R4 joint strobes high byte", d, 16'hA500);

    // R7: high-byte write keeps low byte
    bus_cycle(24'h400002, 6'h39, 1'b1, 1'b1, 2'b10, 16'h3C99, 1'b0, 1'b0, 1'b1, 0, r, d);
    bus_cycle(24'h400002, 6'h39, 1'b1, 1'b0, 2'b11, 16'h0, 1'b0, 1'b0, 1'b0, 0, r, d);
    chk(d == 16'h3C12, "R7 partial write", d, 16'h3C12);

    finish_run();
  end
endmodule